// File: doc/BRIEF.md
# Loop-Primitive Branch Execution Unit

This unit executes the three-byte counted-loop instruction of a small 8/16-bit processor core. The sequencer hands it the opcode byte, the postbyte, the offset byte and the address where the instruction starts, all with a single `start` pulse. The unit decodes the postbyte into four parts: an operation (decrement, increment or test), a counter register, a branch sense and the top bit of a 9-bit signed displacement. It reads the chosen register through a read port into the register file, works out the updated value and the zero condition, and then issues the register write together with the next program counter.

Registers A and B are 8 bits wide. D is the 16-bit pair A:B, with A in the high byte. X, Y and SP are 16 bits wide. Arithmetic and the zero test are done at the width of the selected register. Condition codes are not touched. Any encoding that is not legal completes without a write and leaves the program counter where the instruction began.

Top module: `lpb_unit`

## Requirements
- R1: The opcode byte must equal 0x04. Any other opcode completes with `illegal`=1.
- R2: Postbyte bits 2:0 pick the register: 000=A, 001=B, 100=D (A high, B low), 101=X, 110=Y, 111=SP. `rd_sel` and `wr_sel` carry this code. Codes 010 and 011 are illegal.
- R3: Postbyte bits 7:6 = 00 decrements the register and 10 increments it. A and B wrap modulo 256. D, X, Y and SP wrap modulo 65536. The new value appears on `wr_data` with `wr_en`=1, and for A and B the upper byte of `wr_data` is 0.
- R4: Postbyte bits 7:6 = 01 tests the current value and makes no register write (`wr_en`=0).
- R5: Postbyte bit 5 = 0 takes the branch when the tested value is zero. Bit 5 = 1 takes it when the value is nonzero. A and B are tested on 8 bits only, and the upper byte of `rd_data` is ignored for them. `taken` shows the outcome.
- R6: The displacement is the signed 9-bit value {postbyte bit 4, offset byte}, with range -256..+255. A taken branch gives `pc_out` = `pc_in`+3+displacement. A branch that is not taken gives `pc_out` = `pc_in`+3. Both are modulo 65536.
- R7: Postbyte bit 3 has no effect on any output.
- R8: Postbyte bits 7:6 = 11, a reserved register code, or a wrong opcode makes the instruction complete with `illegal`=1, `wr_en`=0, `taken`=0 and `pc_out` equal to the captured `pc_in`.
- R9: `start` is captured only while the unit is idle. `done` is high for exactly one cycle: the second cycle after the capturing clock edge. The operands are captured at that edge, so later changes to the inputs, and `start` pulses while the unit is busy, are ignored. `wr_en`, `taken` and `illegal` are valid only while `done` is high.
- R10: While reset is asserted, and on leaving it, `done`, `wr_en`, `taken` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction with the presented bytes |
| opcode | input | 8 | Opcode byte |
| postbyte | input | 8 | Operation, sense, offset sign and register selector |
| offset | input | 8 | Low 8 bits of the displacement |
| pc_in | input | 16 | Address of the first instruction byte |
| rd_sel | output | 3 | Register-file read selector (postbyte code) |
| rd_data | input | 16 | Register-file read data, combinational from `rd_sel` |
| done | output | 1 | Instruction completes this cycle |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register to write (postbyte code) |
| wr_data | output | 16 | Updated register value |
| pc_out | output | 16 | Next program counter, valid with `done` |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Illegal encoding detected |

## Verification
The embedded properties assume that `rd_data` settles combinationally from `rd_sel` within the read cycle. They also assume the surrounding core consumes the results only in the `done` cycle. The bench keeps to these assumptions with a register-file model that drives `rd_data` straight from `rd_sel` and puts junk in the unused upper byte. It scrambles every operand input right after the capturing edge and samples outputs only on falling edges. A sweep covers every operation code, every selector and both senses, with register values chosen at zero, one and the wrap points, and program counters chosen near both ends of the address space. Separate cases cover wrong opcodes and a `start` held high while the unit is busy.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  localparam logic [7:0] OPC_LOOP = 8'h04;

  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_RSV = 2'b11
  } lpb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } lpb_state_e;

  typedef struct packed {
    lpb_op_e    op;
    logic       br_nz;
    logic       off_sign;
    logic [2:0] sel;
    logic       wide;
    logic       bad;
  } lpb_dec_t;

endpackage

// File: rtl/lpb_decode.sv
module lpb_decode
  import lpb_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] postbyte,
  output lpb_dec_t   dec
);
  logic sel_rsv;

  always_comb begin
    sel_rsv      = (postbyte[2:1] == 2'b01);
    dec.op       = lpb_op_e'(postbyte[7:6]);
    dec.br_nz    = postbyte[5];
    dec.off_sign = postbyte[4];
    dec.sel      = postbyte[2:0];
    dec.wide     = postbyte[2];
    dec.bad      = (opcode != OPC_LOOP) || (postbyte[7:6] == 2'b11) || sel_rsv;
  end
endmodule

// File: rtl/lpb_alu.sv
module lpb_alu
  import lpb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  lpb_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              is_zero,
  output logic              writes
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] sum;

  always_comb begin
    unique case (op)
      OP_INC:  step = {{(DATA_W-1){1'b0}}, 1'b1};
      OP_DEC:  step = {DATA_W{1'b1}};
      default: step = '0;
    endcase
    sum     = operand + step;
    result  = wide ? sum : {{PAD_W{1'b0}}, sum[NARROW_W-1:0]};
    is_zero = (result == '0);
    writes  = (op == OP_INC) || (op == OP_DEC);
  end
endmodule

// File: rtl/lpb_target.sv
module lpb_target #(
  parameter int PC_W     = 16,
  parameter int OFF_W    = 9,
  parameter int INSN_LEN = 3
) (
  input  logic [PC_W-1:0]  pc_base,
  input  logic [OFF_W-1:0] disp,
  input  logic             take,
  output logic [PC_W-1:0]  pc_next
);
  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] LEN = PC_W'(INSN_LEN);

  logic [PC_W-1:0] fall;
  logic [PC_W-1:0] disp_ext;

  always_comb begin
    fall     = pc_base + LEN;
    disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    pc_next  = take ? (fall + disp_ext) : fall;
  end
endmodule

// File: rtl/lpb_unit.sv
module lpb_unit
  import lpb_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [7:0]        postbyte,
  input  logic [BYTE_W-1:0] offset,
  input  logic [PC_W-1:0]   pc_in,
  output logic [2:0]        rd_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              wr_en,
  output logic [2:0]        wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic [PC_W-1:0]   pc_out,
  output logic              taken,
  output logic              illegal
);
  localparam int OFF_W = BYTE_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // state and enables
  lpb_state_e state_q, state_d;
  logic       cap_en, exe_en;

  always_comb begin
    cap_en  = (state_q == ST_IDLE) && start;
    exe_en  = (state_q == ST_READ);
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // capture stage
  lpb_dec_t          dec_d, dec_q;
  logic [BYTE_W-1:0] off_q;
  logic [PC_W-1:0]   pc_q;

  lpb_decode u_decode (
    .opcode   (opcode),
    .postbyte (postbyte),
    .dec      (dec_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dec_q <= '0;
      off_q <= '0;
      pc_q  <= '0;
    end else if (cap_en) begin
      dec_q <= dec_d;
      off_q <= offset;
      pc_q  <= pc_in;
    end
  end

  // execute stage
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero, alu_wr;
  logic              take_d, we_d;
  logic [PC_W-1:0]   tgt_pc, pc_d;

  lpb_alu #(.DATA_W(DATA_W), .NARROW_W(BYTE_W)) u_alu (
    .op      (dec_q.op),
    .wide    (dec_q.wide),
    .operand (rd_data),
    .result  (alu_res),
    .is_zero (alu_zero),
    .writes  (alu_wr)
  );

  always_comb begin
    take_d = !dec_q.bad && (dec_q.br_nz ? !alu_zero : alu_zero);
    we_d   = !dec_q.bad && alu_wr;
  end

  lpb_target #(.PC_W(PC_W), .OFF_W(OFF_W), .INSN_LEN(3)) u_target (
    .pc_base (pc_q),
    .disp    ({dec_q.off_sign, off_q}),
    .take    (take_d),
    .pc_next (tgt_pc)
  );

  assign pc_d = dec_q.bad ? pc_q : tgt_pc;

  logic              we_q, take_q, bad_q;
  logic [DATA_W-1:0] data_q;
  logic [PC_W-1:0]   npc_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q   <= 1'b0;
      take_q <= 1'b0;
      bad_q  <= 1'b0;
      data_q <= '0;
      npc_q  <= '0;
    end else if (exe_en) begin
      we_q   <= we_d;
      take_q <= take_d;
      bad_q  <= dec_q.bad;
      data_q <= alu_res;
      npc_q  <= pc_d;
    end
  end

  // outputs
  assign done    = (state_q == ST_DONE);
  assign wr_en   = done && we_q;
  assign taken   = done && take_q;
  assign illegal = done && bad_q;
  assign wr_data = data_q;
  assign pc_out  = npc_q;
  assign rd_sel  = dec_q.sel;
  assign wr_sel  = dec_q.sel;

  // properties
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && state_q == ST_IDLE) |=> !done ##1 done);

  assert_no_write_illegal_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> (done && !illegal && !taken) || (done && !illegal));

  assert_illegal_pc_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && illegal) |-> (pc_out == pc_q && !taken && !wr_en));

  assert_test_no_write_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && dec_q.op == OP_TST) |-> !wr_en);

  assert_narrow_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_sel[2]) |-> (wr_data[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/lpb_unit_bench.sv
module lpb_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, postbyte, offset;
  logic [15:0] pc_in;
  logic [2:0]  rd_sel, wr_sel;
  logic [15:0] rd_data, wr_data, pc_out;
  logic        done, wr_en, taken, illegal;

  int checks   = 0;
  int failures = 0;

  logic [7:0]  ra, rb;
  logic [15:0] rx, ry, rsp;

  always #4 clk = ~clk;

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = {8'h5A, ra};
      3'd1:    rd_data = {8'hA5, rb};
      3'd4:    rd_data = {ra, rb};
      3'd5:    rd_data = rx;
      3'd6:    rd_data = ry;
      3'd7:    rd_data = rsp;
      default: rd_data = 16'hDEAD;
    endcase
  end

  lpb_unit u_lpb_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .postbyte(postbyte), .offset(offset), .pc_in(pc_in),
    .rd_sel(rd_sel), .rd_data(rd_data), .done(done), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pc_out(pc_out),
    .taken(taken), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] opc, input logic [7:0] pb,
                     input logic [7:0] off, input logic [15:0] pc,
                     input logic [15:0] val, input bit hold);
    logic [2:0]  sel;
    logic [1:0]  op;
    bit          ill, w8, z, tk, ewe;
    logic [15:0] cur, nv, epc;
    int          disp;
    sel = pb[2:0];
    op  = pb[7:6];
    ra = 8'h33; rb = 8'hC4; rx = 16'h7777; ry = 16'h1111; rsp = 16'h2222;
    case (sel)
      3'd0: ra = val[7:0];
      3'd1: rb = val[7:0];
      3'd4: {ra, rb} = val;
      3'd5: rx = val;
      3'd6: ry = val;
      3'd7: rsp = val;
      default: ;
    endcase
    // expected values from the requirements
    ill  = (opc != 8'h04) || (op == 2'b11) || (sel == 3'd2) || (sel == 3'd3);
    w8   = !sel[2];
    cur  = w8 ? {8'h00, val[7:0]} : val;
    nv   = (op == 2'b00) ? cur - 16'd1 : (op == 2'b10) ? cur + 16'd1 : cur;
    if (w8) nv[15:8] = 8'h00;
    z    = (nv == 16'h0000);
    tk   = !ill && (pb[5] ? !z : z);
    disp = pb[4] ? int'(off) - 256 : int'(off);
    epc  = ill ? pc : (tk ? 16'(int'(pc) + 3 + disp) : pc + 16'd3);
    ewe  = !ill && (op != 2'b01);

    @(negedge clk);
    opcode = opc; postbyte = pb; offset = off; pc_in = pc; start = 1'b1;
    @(negedge clk);
    start = hold; postbyte = ~pb; offset = ~off; pc_in = ~pc; opcode = ~opc;
    chk(done == 1'b0, "R9 done early", 32'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R9 done latency", 32'(done), 1);
    chk(illegal == ill, "R8/R1 illegal", 32'(illegal), 32'(ill));
    chk(wr_en == ewe, "R3/R4 wr_en", 32'(wr_en), 32'(ewe));
    if (ewe) begin
      chk(wr_data == nv, "R3 wr_data", 32'(wr_data), 32'(nv));
      chk(wr_sel == sel, "R2 wr_sel", 32'(wr_sel), 32'(sel));
    end
    chk(taken == tk, "R5 taken", 32'(taken), 32'(tk));
    chk(pc_out == epc, "R6 pc_out", 32'(pc_out), 32'(epc));
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9 single pulse", 32'(done), 0);
    if (hold) begin
      @(negedge clk);
      chk(done == 1'b0, "R9 busy start ignored", 32'(done), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] vals [5];
    logic [15:0] pcs  [5];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0100, 16'h8000};
    pcs  = '{16'h0002, 16'hFFFE, 16'h8000, 16'h1234, 16'h00FF};
    rst_n = 1'b0; start = 1'b0; opcode = 8'h04; postbyte = 8'h00;
    offset = 8'h00; pc_in = 16'h0000;
    ra = 8'h00; rb = 8'h00; rx = '0; ry = '0; rsp = '0;
    repeat (3) @(negedge clk);
    chk({done, wr_en, taken, illegal} == 4'b0, "R10 reset outputs",
        32'({done, wr_en, taken, illegal}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({done, wr_en, taken, illegal} == 4'b0, "R10 after release",
        32'({done, wr_en, taken, illegal}), 0);

    // sweep: R2 R3 R4 R5 R6 R7 across op, selector, sense, bit 3
    for (int op = 0; op < 4; op++)
      for (int sel = 0; sel < 8; sel++)
        for (int nz = 0; nz < 2; nz++)
          for (int vi = 0; vi < 5; vi++) begin
            logic [7:0] pb;
            pb = {2'(op), 1'(nz), 1'((op + sel + vi) % 2), 1'(vi % 2), 3'(sel)};
            run(8'h04, pb, 8'(vi * 8'h37 + sel), pcs[(vi + sel) % 5], vals[vi], 1'b0);
          end

    // R7: bit 3 toggled with everything else equal
    run(8'h04, 8'h05, 8'h10, 16'h4000, 16'h0001, 1'b0);
    run(8'h04, 8'h0D, 8'h10, 16'h4000, 16'h0001, 1'b0);

    // R6: extremes of the displacement
    run(8'h04, 8'h10, 8'h00, 16'h0100, 16'h0001, 1'b0);
    run(8'h04, 8'h00, 8'hFF, 16'h0100, 16'h0001, 1'b0);
    run(8'h04, 8'h10, 8'h00, 16'h0001, 16'h0001, 1'b0);

    // R1: wrong opcodes
    run(8'h05, 8'h05, 8'h20, 16'h3000, 16'h0001, 1'b0);
    run(8'h00, 8'h25, 8'h20, 16'h3000, 16'h0002, 1'b0);
    run(8'h84, 8'h87, 8'h20, 16'h3000, 16'h0001, 1'b0);

    // R9: start held high while busy
    run(8'h04, 8'h85, 8'h40, 16'h5000, 16'hFFFF, 1'b1);
    run(8'h04, 8'h30, 8'h80, 16'h0010, 16'h0005, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule